// File: doc/BRIEF.md
# Master Interrupt Routing Controller

This block is the system-level half of a processor interrupt controller. It samples 32 level-sensitive device interrupt lines into a pending register. Each line belongs to a processor priority level through a fixed, irregular table in which several lines share one level. Lines enabled by a software disable mask are merged into a 16-bit hard-level vector. That vector goes only to the one CPU that software selected as the target, and only while the global master-disable bit is clear.

Lines at level 15 also raise a broadcast request toward every CPU. This request ignores the target and the disable mask. A separate status vector gives the target CPU the levels of all pending lines, disabled ones included. Software reaches the block through a 32-bit word-addressed register window. The window has a pending view, a disable view, a clear-disable port, a set-disable port and a target register. Per-CPU soft interrupt logic sits outside this block and consumes its outputs.

Top module: `irq_master_router`

## Requirements
- R1: After reset the pending register is 0, the target is 0, the disable register holds 0x0FA2007F (reads back as 0 at offset 1), mdis_o is 0, and all level outputs are 0.
- R2: One clock after a change on src_i, pending bit j equals src_i[j]. Lines 23..26 and 31 have level 0 and never set pending. A read at word offset 0 returns pending with bit 31 zero.
- R3: Line-to-level table. Lines 0..6 and 7..13 both map to levels 2,3,5,7,9,11,13 in order. Lines 14 and 15 map to 12. Lines 16..22 map to 6,13,4,10,8,9,11 in order. Lines 27..30 map to 15. Level l appears at bit l of a 16-bit level vector.
- R4: A write at offset 2 clears the disable bits set in (data & 0xF05DFF80). A write at offset 3 sets them. A read at offset 1 returns disable & 0xF05DFF80. Bits outside that mask keep their reset value.
- R5: Disabling a line does not clear its pending bit.
- R6: A write at offset 4 loads the target from data[3:0]. A read at offset 4 returns the target zero-extended. A target of NUM_CPU or more routes to no CPU.
- R7: hard_lvl_o[c*16+l] is 1 only if c is the target, disable bit 31 is clear, and some pending, non-disabled line maps to level l. At most one CPU receives a non-zero vector.
- R8: lvl15_all_o is 1 exactly when any of lines 27..30 is pending. This holds whatever the target and the disable register.
- R9: stat_lvl_o[c*16+l] is 1 only if c is the target and some pending line maps to level l, disabled or not. The hard vector is always a subset of the status vector.
- R10: mdis_o equals disable bit 31. It changes only through a register write.
- R11: An access with be_i not equal to 4'hF is ignored: a write changes nothing and a read returns 0. Reads at offsets 2, 3 and 5..7 return 0. Writes at offsets 0 and 1 have no effect.
- R12: Read data appears on rdata_o in the cycle after the request. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive device interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word offset in the register window |
| be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| hard_lvl_o | output | NUM_CPU*16 | Per-CPU hard-level vector, CPU c at bits c*16+15..c*16 |
| stat_lvl_o | output | NUM_CPU*16 | Per-CPU status level vector, disabled lines included |
| lvl15_all_o | output | 1 | Level-15 broadcast to every CPU |
| mdis_o | output | 1 | Master-disable flag |

## Verification
The checker asserts on every cycle that:
- at most one CPU sees a hard vector;
- master disable forces every hard vector to zero;
- the hard vector stays inside the status vector;
- the broadcast follows lines 27..30 one cycle late;
- read data respects the implemented-bit mask and the pending bit-31 rule;
- partial reads return zero;
- master disable moves only on writes.

Only the bench scenarios can show the exact level of each line in the table, the set/clear effect on the disable mask, retargeting, out-of-range targets, and the reset contents seen through the register window.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int DW       = 32;
  localparam int NSRC     = 32;
  localparam int NLVL     = 16;
  localparam int MDIS_BIT = 31;
  localparam logic [DW-1:0] DIS_RST   = 32'h0FA2_007F;
  localparam logic [DW-1:0] IMPL_MASK = ~DIS_RST;

  // Word offsets; software depends on this layout
  localparam int OFF_PEND = 0;
  localparam int OFF_DIS  = 1;
  localparam int OFF_EN   = 2;
  localparam int OFF_DSET = 3;
  localparam int OFF_TGT  = 4;

  function automatic logic [3:0] src_lvl(input int j);
    logic [3:0] l;
    if (j < 14) begin
      case (j % 7)
        0: l = 4'd2;
        1: l = 4'd3;
        2: l = 4'd5;
        3: l = 4'd7;
        4: l = 4'd9;
        5: l = 4'd11;
        default: l = 4'd13;
      endcase
    end else if (j < 16) begin
      l = 4'd12;
    end else if (j < 23) begin
      case (j - 16)
        0: l = 4'd6;
        1: l = 4'd13;
        2: l = 4'd4;
        3: l = 4'd10;
        4: l = 4'd8;
        5: l = 4'd9;
        default: l = 4'd11;
      endcase
    end else if (j < 27) begin
      l = 4'd0;
    end else if (j < 31) begin
      l = 4'd15;
    end else begin
      l = 4'd0;
    end
    return l;
  endfunction

  function automatic logic [NSRC-1:0] lvl_srcs(input int l);
    logic [NSRC-1:0] m;
    m = '0;
    for (int j = 0; j < NSRC; j++)
      if (l != 0 && int'(src_lvl(j)) == l) m[j] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSRC-1:0] live_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int j = 0; j < NSRC; j++)
      if (src_lvl(j) != 4'd0) m[j] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TGT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NSRC-1:0]   pend_o,
  output logic [DW-1:0]     dis_o,
  output logic [TGT_W-1:0]  tgt_o
);
  localparam logic [NSRC-1:0]   LIVE   = live_mask();
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DIS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFF_DSET);
  localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(OFF_TGT);

  logic          full_acc, wr_en, rd_en;
  logic [DW-1:0] rd_mux, wmask;

  assign full_acc = (be_i == 4'hF);
  assign wr_en    = req_i && we_i && full_acc;
  assign rd_en    = req_i && !we_i;
  assign wmask    = wdata_i & IMPL_MASK;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_PEND:  rd_mux = pend_o & ~(DW'(1) << MDIS_BIT);
      A_DIS:   rd_mux = dis_o & IMPL_MASK;
      A_TGT:   rd_mux = DW'(tgt_o);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= '0;
      dis_o   <= DIS_RST;
      tgt_o   <= '0;
      rdata_o <= '0;
    end else begin
      pend_o <= src_i & LIVE;
      if (wr_en) begin
        case (addr_i)
          A_EN:    dis_o <= dis_o & ~wmask;
          A_DSET:  dis_o <= dis_o | wmask;
          A_TGT:   tgt_o <= wdata_i[TGT_W-1:0];
          default: ;
        endcase
      end
      if (rd_en) rdata_o <= full_acc ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_router_lvlmap.sv
module irq_router_lvlmap
  import irq_router_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [DW-1:0]   dis_i,
  output logic [NLVL-1:0] en_lvl_o,
  output logic [NLVL-1:0] all_lvl_o
);
  logic [NSRC-1:0] en_src;
  assign en_src = pend_i & ~dis_i[NSRC-1:0];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam logic [NSRC-1:0] M = lvl_srcs(l);
    assign en_lvl_o[l]  = |(en_src & M);
    assign all_lvl_o[l] = |(pend_i & M);
  end
endmodule

// File: rtl/irq_router_steer.sv
module irq_router_steer
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int TGT_W   = 4
) (
  input  logic [TGT_W-1:0]        tgt_i,
  input  logic                    mdis_i,
  input  logic [NLVL-1:0]         en_lvl_i,
  input  logic [NLVL-1:0]         all_lvl_i,
  output logic [NUM_CPU*NLVL-1:0] hard_o,
  output logic [NUM_CPU*NLVL-1:0] stat_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    localparam logic [TGT_W-1:0] CID = TGT_W'(c);
    logic hit;
    assign hit = (tgt_i == CID);
    assign hard_o[c*NLVL +: NLVL] = (hit && !mdis_i) ? en_lvl_i : '0;
    assign stat_o[c*NLVL +: NLVL] = hit ? all_lvl_i : '0;
  end
endmodule

// File: rtl/irq_master_router.sv
module irq_master_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 3,
  parameter int TGT_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSRC-1:0]         src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [3:0]              be_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [NUM_CPU*NLVL-1:0] hard_lvl_o,
  output logic [NUM_CPU*NLVL-1:0] stat_lvl_o,
  output logic                    lvl15_all_o,
  output logic                    mdis_o
);
  logic [NSRC-1:0]  pend;
  logic [DW-1:0]    dis;
  logic [TGT_W-1:0] tgt;
  logic [NLVL-1:0]  en_lvl, all_lvl;

  irq_router_regs #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pend_o(pend), .dis_o(dis), .tgt_o(tgt)
  );

  irq_router_lvlmap u_map (
    .pend_i(pend), .dis_i(dis),
    .en_lvl_o(en_lvl), .all_lvl_o(all_lvl)
  );

  irq_router_steer #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) u_steer (
    .tgt_i(tgt), .mdis_i(mdis_o),
    .en_lvl_i(en_lvl), .all_lvl_i(all_lvl),
    .hard_o(hard_lvl_o), .stat_o(stat_lvl_o)
  );

  assign mdis_o      = dis[MDIS_BIT];
  assign lvl15_all_o = all_lvl[NLVL-1];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NSRC-1:0]         src_i,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [3:0]              be_i,
  input logic [DW-1:0]           rdata_o,
  input logic [NUM_CPU*NLVL-1:0] hard_lvl_o,
  input logic [NUM_CPU*NLVL-1:0] stat_lvl_o,
  input logic                    lvl15_all_o,
  input logic                    mdis_o
);
  logic [NUM_CPU-1:0] cpu_hot;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_hot
    assign cpu_hot[c] = |hard_lvl_o[c*NLVL +: NLVL];
  end

  logic rd_full;
  assign rd_full = req_i && !we_i && (be_i == 4'hF);

  assert_one_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cpu_hot));
  assert_mdis_gates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdis_o |-> (hard_lvl_o == '0));
  assert_hard_in_stat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_lvl_o & ~stat_lvl_o) == '0);
  assert_l15_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (lvl15_all_o == (|$past(src_i[30:27]))));
  assert_dis_rd_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full && addr_i == ADDR_W'(OFF_DIS)) |=> ((rdata_o & ~IMPL_MASK) == '0));
  assert_pend_bit31_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full && addr_i == ADDR_W'(OFF_PEND)) |=> !rdata_o[MDIS_BIT]);
  assert_partial_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && be_i != 4'hF) |=> (rdata_o == '0));
  assert_mdis_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mdis_o));
endmodule

bind irq_master_router irq_router_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .be_i(be_i), .rdata_o(rdata_o), .hard_lvl_o(hard_lvl_o),
  .stat_lvl_o(stat_lvl_o), .lvl15_all_o(lvl15_all_o), .mdis_o(mdis_o)
);

// File: tb/sim_irq_master_router.sv
`timescale 1ns/1ps
module sim_irq_master_router;
  localparam int NCPU = 4;
  localparam logic [31:0] LIVE = 32'h787F_FFFF; // R2: lines 23..26, 31 never pend

  typedef struct packed {
    logic [31:0] src;
    logic [15:0] hard;
    logic [15:0] stat;
    logic        l15;
  } vec_t;

  // Reset disable state, target 0: expected cpu0 hard/status vectors (R3)
  localparam vec_t VECS [13] = '{
    '{32'h0000_0000, 16'h0000, 16'h0000, 1'b0},
    '{32'h0000_0001, 16'h0000, 16'h0004, 1'b0},
    '{32'h0000_0080, 16'h0004, 16'h0004, 1'b0},
    '{32'h0000_4000, 16'h1000, 16'h1000, 1'b0},
    '{32'h0001_0000, 16'h0040, 16'h0040, 1'b0},
    '{32'h0002_0000, 16'h0000, 16'h2000, 1'b0},
    '{32'h0800_0000, 16'h0000, 16'h8000, 1'b1},
    '{32'h1000_0000, 16'h8000, 16'h8000, 1'b1},
    '{32'h8780_0000, 16'h0000, 16'h0000, 1'b0},
    '{32'h0000_3F80, 16'h2AAC, 16'h2AAC, 1'b0},
    '{32'h0074_0000, 16'h0910, 16'h0B10, 1'b0},
    '{32'h0008_0000, 16'h0400, 16'h0400, 1'b0},
    '{32'hFFFF_FFFF, 16'hBFFC, 16'hBFFC, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0, wdata = '0;
  logic req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] rdata;
  logic [NCPU*16-1:0] hard, stat;
  logic l15, mdis;
  int n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  irq_master_router #(.NUM_CPU(NCPU)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .hard_lvl_o(hard), .stat_lvl_o(stat), .lvl15_all_o(l15), .mdis_o(mdis)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; be = 4'hF;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] b, output logic [31:0] v);
    bus(1'b0, a, 32'h0, b);
    v = rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk); src = v;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mdis", 64'(mdis), 64'h0);
    chk("R1 hard", 64'(hard), 64'h0);
    chk("R1 stat", 64'(stat), 64'h0);
    rd(3'd0, 4'hF, rv); chk("R1 pend rd", 64'(rv), 64'h0);
    rd(3'd1, 4'hF, rv); chk("R1 dis rd", 64'(rv), 64'h0);
    rd(3'd4, 4'hF, rv); chk("R1 tgt rd", 64'(rv), 64'h0);

    // Table walk: R2 R3 R7 R8 R9
    for (int i = 0; i < 13; i++) begin
      set_src(VECS[i].src);
      chk("R3 hard cpu0", 64'(hard[15:0]), 64'(VECS[i].hard));
      chk("R7 other cpus", 64'(hard[NCPU*16-1:16]), 64'h0);
      chk("R9 stat cpu0", 64'(stat[15:0]), 64'(VECS[i].stat));
      chk("R8 l15", 64'(l15), 64'(VECS[i].l15));
      rd(3'd0, 4'hF, rv);
      chk("R2 pend rd", 64'(rv), 64'(VECS[i].src & LIVE));
    end

    set_src(32'h1000_0080);
    chk("R7 base", 64'(hard[15:0]), 64'h8004);

    // R4 R5 R10 disable set/clear
    bus(1'b1, 3'd3, 32'hFFFF_FFFF, 4'hF);
    rd(3'd1, 4'hF, rv); chk("R4 dis set", 64'(rv), 64'hF05D_FF80);
    chk("R10 mdis set", 64'(mdis), 64'h1);
    chk("R7 mdis gates", 64'(hard), 64'h0);
    chk("R9 stat under mdis", 64'(stat[15:0]), 64'h8004);
    chk("R8 l15 ignores dis", 64'(l15), 64'h1);
    rd(3'd0, 4'hF, rv); chk("R5 pend kept", 64'(rv), 64'h1000_0080);
    bus(1'b1, 3'd2, 32'h8000_0000, 4'hF);
    rd(3'd1, 4'hF, rv); chk("R4 clr mdis", 64'(rv), 64'h705D_FF80);
    chk("R10 mdis clr", 64'(mdis), 64'h0);
    chk("R7 line dis", 64'(hard[15:0]), 64'h0);
    bus(1'b1, 3'd2, 32'h0000_0080, 4'hF);
    chk("R7 line en", 64'(hard[15:0]), 64'h0004);
    bus(1'b1, 3'd3, 32'h0000_007F, 4'hF);
    bus(1'b1, 3'd2, 32'h0800_0000, 4'hF);
    rd(3'd1, 4'hF, rv); chk("R4 unimpl bits", 64'(rv), 64'h705D_FF00);

    // R6 target
    bus(1'b1, 3'd4, 32'h0000_0012, 4'hF);
    rd(3'd4, 4'hF, rv); chk("R6 tgt rd", 64'(rv), 64'h2);
    chk("R6 hard cpu2", 64'(hard[47:32]), 64'h0004);
    chk("R6 hard cpu0", 64'(hard[15:0]), 64'h0);
    chk("R9 stat cpu2", 64'(stat[47:32]), 64'h8004);
    bus(1'b1, 3'd4, 32'h0000_0005, 4'hF);
    rd(3'd4, 4'hF, rv); chk("R6 tgt out of range", 64'(rv), 64'h5);
    chk("R6 no hard", 64'(hard), 64'h0);
    chk("R6 no stat", 64'(stat), 64'h0);
    chk("R8 l15 any tgt", 64'(l15), 64'h1);

    // R11 partial and unmapped
    bus(1'b1, 3'd4, 32'h0000_0001, 4'h7);
    rd(3'd4, 4'hF, rv); chk("R11 partial wr", 64'(rv), 64'h5);
    rd(3'd4, 4'h3, rv); chk("R11 partial rd", 64'(rv), 64'h0);
    rd(3'd2, 4'hF, rv); chk("R11 rd off2", 64'(rv), 64'h0);
    rd(3'd7, 4'hF, rv); chk("R11 rd off7", 64'(rv), 64'h0);
    bus(1'b1, 3'd1, 32'h0000_0000, 4'hF);
    bus(1'b1, 3'd0, 32'hFFFF_FFFF, 4'hF);
    rd(3'd1, 4'hF, rv); chk("R11 wr off1", 64'(rv), 64'h705D_FF00);

    // R12 read data holds
    repeat (3) @(negedge clk);
    chk("R12 hold", 64'(rdata), 64'h705D_FF00);

    // R1 reset again
    set_src(32'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mdis 2", 64'(mdis), 64'h0);
    rd(3'd1, 4'hF, rv); chk("R1 dis 2", 64'(rv), 64'h0);
    rd(3'd4, 4'hF, rv); chk("R1 tgt 2", 64'(rv), 64'h0);
    set_src(32'h0000_0001);
    chk("R1 line0 off", 64'(hard[15:0]), 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule